// File: doc/BRIEF.md
# PWM Global Shadow Load Controller

This block decides when the working values of one PWM channel are refreshed. It keeps two copies of four timing registers: a period, two compare levels and a deadband delay. Software writes go to the shadow copy only. The active copy, which the waveform logic would read, takes the shadow value only when a load event qualifies. A load event is a counter-zero strobe, a counter-period strobe, or a force request.

Each register can follow its own load event. It can also join a global group, and every member of that group moves on one shared event. The shared event passes through a prescaler that counts qualifying strobes. An optional one-shot mode allows one group transfer for each arm request. Arm and force requests from linked neighbour channels arrive as plain strobes and act exactly like the local requests. This lets several channels move to new values on the same edge.

Top module: `pwm_gld_ctrl`

## Requirements
- R1: A shadow write (select 0 = period, 1 = compare A, 2 = compare B, 3 = deadband) changes only the selected shadow copy. An active copy keeps its value in every cycle without a load for that register.
- R2: A register that is not in the global group loads on its own 2-bit select. The encodings are 0 = counter zero, 1 = counter period, 2 = either strobe, 3 = never. A register is not in the group when global mode is off or its mask bit is 0.
- R3: With global mode on, all registers whose mask bit is 1 load together on the global 3-bit select. The encodings are 0 = counter zero, 1 = counter period, 2 = either strobe, 3 = force only, 4 to 7 = no load.
- R4: The global group loads on every Nth qualifying strobe, where N is the 3-bit prescale value. A value of 0 acts as 1.
- R5: The strobe counter returns to zero on every group load and on every prescale write. A strobe in the same cycle as a prescale write neither counts nor loads.
- R6: With one-shot mode on, strobes count and load only while the arm flag is set. A group load clears the flag, which blocks later loads until a new arm request.
- R7: The local arm input and the linked arm input set the arm flag in the same way. An arm request in the same cycle as a flag-clearing load leaves the flag set.
- R8: A local or linked force request loads the global group at the clock edge one cycle after the request. It also clears the arm flag and the strobe counter. With global mode off, it has no effect.
- R9: When a shadow write and a load of the same register fall on one edge, the active copy takes the previous shadow value and the shadow copy keeps the new write.
- R10: After reset, all shadow and active copies read zero, the arm flag is clear, the counter is zero and the prescale value is 0.
- R11: With global mode on, a register whose mask bit is 0 still follows its own select, independently of the group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_zero_i | input | 1 | One-cycle strobe: PWM counter at zero |
| cnt_prd_i | input | 1 | One-cycle strobe: PWM counter at period |
| sh_wr_i | input | 1 | Shadow write enable |
| sh_sel_i | input | 2 | Shadow register select |
| sh_data_i | input | 16 | Shadow write data |
| ind_sel_i | input | 8 | Per-register 2-bit individual load select, register k at bits 2k+1:2k |
| gld_en_i | input | 1 | Global load mode on |
| gld_mask_i | input | 4 | Global group membership, bit k for register k |
| gld_evt_i | input | 3 | Global load event select |
| gld_cnt_wr_i | input | 1 | Prescale value write strobe |
| gld_cnt_i | input | 3 | Prescale value written on gld_cnt_wr_i |
| oneshot_en_i | input | 1 | One-shot mode on |
| arm_i | input | 1 | Local arm request strobe |
| arm_link_i | input | 1 | Arm request strobe from a linked channel |
| force_i | input | 1 | Local force request strobe |
| force_link_i | input | 1 | Force request strobe from a linked channel |
| shadow_o | output | 64 | Shadow copies, register k at bits 16k+15:16k |
| active_o | output | 64 | Active copies, register k at bits 16k+15:16k |

## Verification
A wrong counter or arm flag stays hidden until the next qualifying strobe. It then shows as a group load that comes one prescale period early or late, or as a load that should have been blocked, on all masked registers at once. A wrong force pipeline shows on the edge after the request, as a missing load or a load one cycle late. A membership or select error shows as one register that moves on the wrong strobe, so the bench compares every active slice after every edge against a reference model. This catches such an error within one PWM strobe of its cause.

// File: rtl/pwm_gld_pkg.sv
// Shared sizes and event encodings for the PWM global shadow load controller.
package pwm_gld_pkg;
    localparam int NREG = 4;   // period, compare A, compare B, deadband
    localparam int DW   = 16;  // register width
    localparam int EVW  = 3;   // event select width
    localparam int PRW  = 3;   // prescale field width

    localparam logic [EVW-1:0] EV_ZERO  = 3'd0;
    localparam logic [EVW-1:0] EV_PRD   = 3'd1;
    localparam logic [EVW-1:0] EV_BOTH  = 3'd2;
    localparam logic [EVW-1:0] EV_FORCE = 3'd3;
endpackage

// File: rtl/pwm_gld_evt_dec.sv
// Event decoder: turns a load-event select and the counter strobes into one hit.
// Assumes the strobes last one cycle. Force-only and reserved codes never hit.
module pwm_gld_evt_dec
    import pwm_gld_pkg::*;
(
    input  logic           zero_i,
    input  logic           prd_i,
    input  logic [EVW-1:0] sel_i,
    output logic           hit_o
);
    // Choose which counter strobe(s) qualify
    always_comb begin
        case (sel_i)
            EV_ZERO: hit_o = zero_i;
            EV_PRD:  hit_o = prd_i;
            EV_BOTH: hit_o = zero_i | prd_i;
            default: hit_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/pwm_gld_slot.sv
// One register slot: a shadow copy and an active copy.
// The load copies the pre-edge shadow value, so a write on the same edge
// reaches only the shadow copy.
module pwm_gld_slot #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  logic [DW-1:0] data_i,
    input  logic          load_i,
    output logic [DW-1:0] shadow_o,
    output logic [DW-1:0] active_o
);
    logic [DW-1:0] shadow_q;
    logic [DW-1:0] active_q;

    // Capture software writes in the shadow copy
    always_ff @(posedge clk) begin
        if (!rst_n)    shadow_q <= '0;
        else if (wr_i) shadow_q <= data_i;
    end

    // Move the shadow copy into the active copy on a load
    always_ff @(posedge clk) begin
        if (!rst_n)      active_q <= '0;
        else if (load_i) active_q <= shadow_q;
    end

    assign shadow_o = shadow_q;
    assign active_o = active_q;
endmodule

// File: rtl/pwm_gld_seq.sv
// Global load sequencer. It holds the prescale value, the strobe counter, the
// one-shot arm flag and the one-cycle force pipeline, and it raises fire_o on
// the edge where the global group must load.
// Priority: a pending force first, then a prescale write, then a counted strobe.
module pwm_gld_seq
    import pwm_gld_pkg::*;
#(
    parameter int PW = PRW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          gld_en_i,
    input  logic          evt_hit_i,
    input  logic          prd_wr_i,
    input  logic [PW-1:0] prd_data_i,
    input  logic          oneshot_i,
    input  logic          arm_req_i,
    input  logic          force_req_i,
    output logic          fire_o,
    output logic [PW-1:0] cnt_o,
    output logic          arm_o,
    output logic          force_q_o,
    output logic [PW-1:0] prd_o
);
    logic [PW-1:0] prd_q;
    logic [PW-1:0] cnt_q;
    logic          arm_q;
    logic          force_q;
    logic [PW:0]   tgt;
    logic [PW:0]   cnt_inc;
    logic          qual;
    logic          done;
    logic          frc_act;

    // Derive the target count, the strobe qualification and the fire decision
    always_comb begin
        tgt     = (prd_q == '0) ? {{PW{1'b0}}, 1'b1} : {1'b0, prd_q};
        cnt_inc = {1'b0, cnt_q} + {{PW{1'b0}}, 1'b1};
        frc_act = gld_en_i & force_q;
        qual    = gld_en_i & evt_hit_i & (~oneshot_i | arm_q);
        done    = (cnt_inc >= tgt);
        fire_o  = frc_act | (~prd_wr_i & qual & done);
    end

    // Hold the prescale value written by software
    always_ff @(posedge clk) begin
        if (!rst_n)        prd_q <= '0;
        else if (prd_wr_i) prd_q <= prd_data_i;
    end

    // Count qualifying strobes and clear on load, force or prescale write
    always_ff @(posedge clk) begin
        if (!rst_n)                   cnt_q <= '0;
        else if (frc_act || prd_wr_i) cnt_q <= '0;
        else if (qual)                cnt_q <= done ? '0 : cnt_inc[PW-1:0];
    end

    // Set the arm flag on request; clear it on a one-shot load or a force
    always_ff @(posedge clk) begin
        if (!rst_n)                             arm_q <= 1'b0;
        else if (arm_req_i)                     arm_q <= 1'b1;
        else if (frc_act || (fire_o && oneshot_i)) arm_q <= 1'b0;
    end

    // Delay the force request by one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) force_q <= 1'b0;
        else        force_q <= force_req_i;
    end

    assign cnt_o     = cnt_q;
    assign arm_o     = arm_q;
    assign force_q_o = force_q;
    assign prd_o     = prd_q;
endmodule

// File: rtl/pwm_gld_ctrl.sv
// PWM global shadow load controller, top level.
// Each register slot loads either on its own select or, when it belongs to
// the global group, on the sequencer's fire signal. Linked arm and force
// strobes are ORed with the local ones. Counter strobes are one cycle wide.
module pwm_gld_ctrl
    import pwm_gld_pkg::*;
#(
    parameter  int NREGS = NREG,
    parameter  int W     = DW,
    localparam int SELW  = (NREGS > 1) ? $clog2(NREGS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cnt_zero_i,
    input  logic               cnt_prd_i,
    input  logic               sh_wr_i,
    input  logic [SELW-1:0]    sh_sel_i,
    input  logic [W-1:0]       sh_data_i,
    input  logic [2*NREGS-1:0] ind_sel_i,
    input  logic               gld_en_i,
    input  logic [NREGS-1:0]   gld_mask_i,
    input  logic [EVW-1:0]     gld_evt_i,
    input  logic               gld_cnt_wr_i,
    input  logic [PRW-1:0]     gld_cnt_i,
    input  logic               oneshot_en_i,
    input  logic               arm_i,
    input  logic               arm_link_i,
    input  logic               force_i,
    input  logic               force_link_i,
    output logic [NREGS*W-1:0] shadow_o,
    output logic [NREGS*W-1:0] active_o
);
    logic             glob_hit;
    logic             seq_fire;
    logic [PRW-1:0]   seq_cnt;
    logic             seq_arm;
    logic             seq_force_q;
    logic [PRW-1:0]   seq_prd;
    logic             arm_req;
    logic             force_req;
    logic [NREGS-1:0] ind_hit;
    logic [NREGS-1:0] ld_vec;

    // Merge local and linked requests
    assign arm_req   = arm_i | arm_link_i;
    assign force_req = force_i | force_link_i;

    pwm_gld_evt_dec u_glob_dec (
        .zero_i (cnt_zero_i),
        .prd_i  (cnt_prd_i),
        .sel_i  (gld_evt_i),
        .hit_o  (glob_hit)
    );

    pwm_gld_seq #(.PW(PRW)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .gld_en_i    (gld_en_i),
        .evt_hit_i   (glob_hit),
        .prd_wr_i    (gld_cnt_wr_i),
        .prd_data_i  (gld_cnt_i),
        .oneshot_i   (oneshot_en_i),
        .arm_req_i   (arm_req),
        .force_req_i (force_req),
        .fire_o      (seq_fire),
        .cnt_o       (seq_cnt),
        .arm_o       (seq_arm),
        .force_q_o   (seq_force_q),
        .prd_o       (seq_prd)
    );

    for (genvar k = 0; k < NREGS; k++) begin : g_slot
        logic wr_k;

        pwm_gld_evt_dec u_ind_dec (
            .zero_i (cnt_zero_i),
            .prd_i  (cnt_prd_i),
            .sel_i  ({1'b0, ind_sel_i[2*k +: 2]}),
            .hit_o  (ind_hit[k])
        );

        // Route the load: global fire for group members, own hit otherwise
        assign ld_vec[k] = (gld_en_i && gld_mask_i[k]) ? seq_fire : ind_hit[k];
        assign wr_k      = sh_wr_i && (sh_sel_i == SELW'(k));

        pwm_gld_slot #(.DW(W)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_i     (wr_k),
            .data_i   (sh_data_i),
            .load_i   (ld_vec[k]),
            .shadow_o (shadow_o[k*W +: W]),
            .active_o (active_o[k*W +: W])
        );
    end
endmodule

// File: rtl/pwm_gld_ctrl_chk.sv
// Assertion checker for pwm_gld_ctrl. It is bound into the top module and
// reads the load vector and the sequencer state.
module pwm_gld_ctrl_chk
    import pwm_gld_pkg::*;
#(
    parameter int NREGS = NREG,
    parameter int W     = DW
) (
    input logic               clk,
    input logic               rst_n,
    input logic               gld_en_i,
    input logic [EVW-1:0]     gld_evt_i,
    input logic               gld_cnt_wr_i,
    input logic               oneshot_en_i,
    input logic               arm_req,
    input logic               seq_fire,
    input logic [PRW-1:0]     seq_cnt,
    input logic               seq_arm,
    input logic               seq_force_q,
    input logic [PRW-1:0]     seq_prd,
    input logic [NREGS-1:0]   ld_vec,
    input logic [NREGS*W-1:0] shadow_o,
    input logic [NREGS*W-1:0] active_o
);
    for (genvar k = 0; k < NREGS; k++) begin : g_reg
        // R1: no load means the active copy holds its value
        a_r1_active_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !ld_vec[k] |=> $stable(active_o[k*W +: W]));
        // R9: a load takes the shadow value from before the edge
        a_r9_old_shadow: assert property (@(posedge clk) disable iff (!rst_n)
            ld_vec[k] |=> active_o[k*W +: W] == $past(shadow_o[k*W +: W]));
    end

    // R4: the counter stays below the effective prescale target
    a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, seq_cnt} < ((seq_prd == '0) ? 4'd1 : {1'b0, seq_prd})));

    // R5: a prescale write leaves the counter at zero
    a_r5_cnt_clear: assert property (@(posedge clk) disable iff (!rst_n)
        gld_cnt_wr_i |=> seq_cnt == '0);

    // R6: a one-shot load without a new arm request clears the arm flag
    a_r6_arm_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (oneshot_en_i && seq_fire && !arm_req) |=> !seq_arm);

    // R7: an arm request always leaves the flag set
    a_r7_arm_set: assert property (@(posedge clk) disable iff (!rst_n)
        arm_req |=> seq_arm);

    // R8: a pending force in global mode fires the group
    a_r8_force_fire: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_force_q && gld_en_i) |-> seq_fire);

    // R3: force-only and reserved selects never fire without a force
    a_r3_no_strobe_fire: assert property (@(posedge clk) disable iff (!rst_n)
        (gld_evt_i >= EV_FORCE && !seq_force_q) |-> !seq_fire);
endmodule

bind pwm_gld_ctrl pwm_gld_ctrl_chk #(.NREGS(NREGS), .W(W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .gld_en_i     (gld_en_i),
    .gld_evt_i    (gld_evt_i),
    .gld_cnt_wr_i (gld_cnt_wr_i),
    .oneshot_en_i (oneshot_en_i),
    .arm_req      (arm_req),
    .seq_fire     (seq_fire),
    .seq_cnt      (seq_cnt),
    .seq_arm      (seq_arm),
    .seq_force_q  (seq_force_q),
    .seq_prd      (seq_prd),
    .ld_vec       (ld_vec),
    .shadow_o     (shadow_o),
    .active_o     (active_o)
);

// File: tb/pwm_gld_ctrl_tb.sv
`timescale 1ns/1ps
// Testbench for pwm_gld_ctrl: directed corner cases, then seeded random
// stimulus, each compared against a reference model written from the requirements.
module pwm_gld_ctrl_tb;
    localparam int N = 4;
    localparam int W = 16;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           cnt_zero_i, cnt_prd_i, sh_wr_i;
    logic [1:0]     sh_sel_i;
    logic [W-1:0]   sh_data_i;
    logic [2*N-1:0] ind_sel_i;
    logic           gld_en_i;
    logic [N-1:0]   gld_mask_i;
    logic [2:0]     gld_evt_i;
    logic           gld_cnt_wr_i;
    logic [2:0]     gld_cnt_i;
    logic           oneshot_en_i, arm_i, arm_link_i, force_i, force_link_i;
    logic [N*W-1:0] shadow_o, active_o;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // reference model state
    logic [W-1:0] m_sh  [N];
    logic [W-1:0] m_act [N];
    int           m_cnt, m_prd;
    bit           m_arm, m_fq;

    always #2 clk = ~clk;

    pwm_gld_ctrl u_dut (.*);

    // Event hit for a select code, per the R2 and R3 encodings
    function automatic bit hit(input int sel, input bit z, input bit p);
        case (sel)
            0: return z;
            1: return p;
            2: return z | p;
            default: return 1'b0;
        endcase
    endfunction

    // Advance the model by one clock edge with the current inputs
    task automatic model_step();
        bit gfire = 0;
        bit ghit  = hit(int'(gld_evt_i), cnt_zero_i, cnt_prd_i);
        int tgt   = (m_prd == 0) ? 1 : m_prd;
        bit qual  = gld_en_i && ghit && (!oneshot_en_i || m_arm);
        bit narm  = m_arm;
        int ncnt  = m_cnt;
        if (gld_en_i && m_fq) begin
            gfire = 1; ncnt = 0; narm = 0;
        end else if (gld_cnt_wr_i) begin
            ncnt = 0;
        end else if (qual) begin
            if (m_cnt + 1 >= tgt) begin
                gfire = 1; ncnt = 0;
                if (oneshot_en_i) narm = 0;
            end else ncnt = m_cnt + 1;
        end
        if (arm_i || arm_link_i) narm = 1;
        for (int k = 0; k < N; k++) begin
            bit ld = (gld_en_i && gld_mask_i[k]) ? gfire
                     : hit(int'(ind_sel_i[2*k +: 2]), cnt_zero_i, cnt_prd_i);
            if (ld) m_act[k] = m_sh[k];
        end
        if (sh_wr_i) m_sh[sh_sel_i] = sh_data_i;
        if (gld_cnt_wr_i) m_prd = int'(gld_cnt_i);
        m_cnt = ncnt;
        m_arm = narm;
        m_fq  = force_i || force_link_i;
    endtask

    task automatic check_vec(input string tag, input logic [N*W-1:0] act,
                             input logic [N*W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [N*W-1:0] pack(input logic [W-1:0] a [N]);
        logic [N*W-1:0] v;
        for (int k = 0; k < N; k++) v[k*W +: W] = a[k];
        return v;
    endfunction

    task automatic clear_strobes();
        cnt_zero_i = 0; cnt_prd_i = 0; sh_wr_i = 0; gld_cnt_wr_i = 0;
        arm_i = 0; arm_link_i = 0; force_i = 0; force_link_i = 0;
    endtask

    // One clock: model the edge, let the DUT take it, compare at the falling edge
    task automatic cyc(input string tag);
        model_step();
        @(posedge clk);
        @(negedge clk);
        check_vec({tag, " active"}, active_o, pack(m_act));
        check_vec({tag, " shadow"}, shadow_o, pack(m_sh));
        clear_strobes();
    endtask

    task automatic wr(input int sel, input logic [W-1:0] d);
        sh_wr_i = 1; sh_sel_i = 2'(sel); sh_data_i = d;
    endtask

    initial begin : watchdog
        #400000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        int unused_seed;
        unused_seed = $urandom(32'h5eed_1234);
        clear_strobes();
        sh_sel_i = 0; sh_data_i = 0; ind_sel_i = 8'hFF; gld_en_i = 0;
        gld_mask_i = 0; gld_evt_i = 0; gld_cnt_i = 0; oneshot_en_i = 0;
        rst_n = 0;
        for (int k = 0; k < N; k++) begin m_sh[k] = 0; m_act[k] = 0; end
        m_cnt = 0; m_prd = 0; m_arm = 0; m_fq = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R10: reset state
        check_vec("R10 reset active", active_o, '0);
        check_vec("R10 reset shadow", shadow_o, '0);

        // R1: writes with every individual select at never
        wr(0, 16'h1111); cyc("R1");
        wr(1, 16'h2222); cyc("R1");
        wr(2, 16'h3333); cnt_zero_i = 1; cyc("R1");
        wr(3, 16'h4444); cnt_prd_i = 1; cyc("R1");
        check_vec("R1 active unchanged", active_o, '0);

        // R2: register 1 on period only, register 2 on either
        ind_sel_i = 8'b11_10_01_11;
        cnt_zero_i = 1; cyc("R2 zero");
        cnt_prd_i = 1; cyc("R2 period");
        check_vec("R2 explicit", active_o, {16'h0, 16'h3333, 16'h2222, 16'h0});

        // R3: global group on zero, prescale 1 via value 0
        ind_sel_i = 8'hFF; gld_en_i = 1; gld_mask_i = 4'hF; gld_evt_i = 0;
        cnt_prd_i = 1; cyc("R3 wrong strobe");
        cnt_zero_i = 1; cyc("R3 group");
        check_vec("R3 explicit", active_o, {16'h4444, 16'h3333, 16'h2222, 16'h1111});
        for (int e = 3; e < 8; e++) begin
            gld_evt_i = 3'(e); wr(0, 16'(16'hA000 + e)); cyc("R3 reserved");
            cnt_zero_i = 1; cnt_prd_i = 1; cyc("R3 reserved");
        end

        // R4 and R5: prescale 3, a rewrite mid-count restarts the count
        gld_evt_i = 2; gld_cnt_wr_i = 1; gld_cnt_i = 3; cyc("R5 write");
        for (int i = 0; i < 3; i++) begin
            wr(1, 16'(16'hB000 + i)); cnt_zero_i = 1; cyc("R4 count");
        end
        cnt_prd_i = 1; cyc("R4");
        gld_cnt_wr_i = 1; gld_cnt_i = 2; cnt_zero_i = 1; cyc("R5 same cycle");
        cnt_zero_i = 1; cyc("R5"); wr(2, 16'hC0DE); cnt_prd_i = 1; cyc("R5 load");

        // R6 and R7: one-shot, linked arm
        gld_cnt_wr_i = 1; gld_cnt_i = 1; oneshot_en_i = 1; cyc("R6 setup");
        wr(0, 16'h0D01); cnt_zero_i = 1; cyc("R6 unarmed");
        arm_link_i = 1; cyc("R7 link arm");
        cnt_zero_i = 1; cyc("R6 armed load");
        wr(0, 16'h0D02); cyc("R6");
        cnt_zero_i = 1; cyc("R6 blocked");
        arm_i = 1; cyc("R7 local arm");
        cnt_prd_i = 1; arm_i = 1; cyc("R7 arm at load");
        cnt_zero_i = 1; cyc("R7 still armed");

        // R8: linked force loads one cycle later and clears the arm flag
        wr(3, 16'hF0F0); arm_i = 1; cyc("R8 prep");
        force_link_i = 1; cyc("R8 request");
        cyc("R8 load");
        wr(3, 16'hF1F1); cnt_zero_i = 1; cyc("R8 arm cleared");
        gld_en_i = 0; force_i = 1; cyc("R8 off"); cyc("R8 no effect");
        gld_en_i = 1; oneshot_en_i = 0;

        // R9: a write and a load on the same edge
        gld_evt_i = 0; wr(2, 16'h9999); cnt_zero_i = 1; cyc("R9");
        cnt_zero_i = 1; cyc("R9 next");

        // R11: partial mask, unmasked register on its own select
        gld_mask_i = 4'b0101; ind_sel_i = 8'b00_01_00_01;
        wr(1, 16'h1B1B); cnt_prd_i = 1; cyc("R11 own");
        wr(3, 16'h3B3B); cnt_zero_i = 1; cyc("R11 group");

        // Random phase covering all requirements
        for (int i = 0; i < 4000; i++) begin
            if (i % 64 == 0) begin
                gld_en_i     = ($urandom % 4) != 0;
                gld_mask_i   = 4'($urandom);
                gld_evt_i    = 3'($urandom % 5);
                ind_sel_i    = 8'($urandom);
                oneshot_en_i = $urandom % 2;
            end
            cnt_zero_i   = ($urandom % 4) == 0;
            cnt_prd_i    = ($urandom % 4) == 0;
            if ($urandom % 2) wr(int'($urandom % 4), 16'($urandom));
            gld_cnt_wr_i = ($urandom % 32) == 0;
            gld_cnt_i    = 3'($urandom);
            arm_i        = ($urandom % 10) == 0;
            arm_link_i   = ($urandom % 12) == 0;
            force_i      = ($urandom % 24) == 0;
            force_link_i = ($urandom % 24) == 0;
            cyc("R1-random R2 R3 R4 R5 R6 R7 R8 R9 R11");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule